// File: doc/BRIEF.md
# Bus Acknowledge Wait-State Generator

This block sits beside a bus slave and decides when the slave tells the processor that a transfer is complete. It watches an active-low select input. Once it sees the select low, it holds its active-low acknowledge high for a fixed number of clock edges. This stretches the processor's bus cycle by that many wait states. After that it drives the acknowledge low and keeps it low for as long as the select stays low.

The machine is fully synchronous. It samples select and reset only on the rising clock edge and never changes state without an edge. If the select is released while the delay is still counting, the count is dropped and the machine goes back to idle. The next select therefore always waits the full delay again. The reset input is the system-wide active-low reset, and it overrides everything else.

Top module: `wait_ack_gen`

## Requirements
- R1: After a rising edge that samples `rst_n` low, `xfer_ack_n` is high (inactive). The machine is idle, so a later select needs the full delay.
- R2: With the default `WAIT_CYCLES` = 3, `xfer_ack_n` goes low right after the third consecutive rising edge that samples `sel_n` low. The first of those edges is the first one that sees `sel_n` low while the machine is idle.
- R3: `xfer_ack_n` goes high right after the first rising edge that samples `sel_n` high.
- R4: If `sel_n` is sampled high before the count completes, the count is discarded and `xfer_ack_n` stays high throughout.
- R5: Reset has priority. `rst_n` sampled low forces `xfer_ack_n` high whatever the state (idle, either wait state, or acknowledging) and whatever the value of `sel_n`.
- R6: While the acknowledge is low, it stays low on every edge that samples `sel_n` low, however long the select is held.
- R7: After an abort or a release, a new select assertion again needs the full `WAIT_CYCLES` edges. A shortened acknowledge never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, shared with the system |
| sel_n | input | 1 | Active-low select from the address decoder |
| xfer_ack_n | output | 1 | Active-low transfer acknowledge, registered |

## Verification
Every result is due exactly one rising edge after the input that causes it, because the acknowledge comes from a single register. The exception is assertion itself, which appears after the third consecutive edge that samples the select low. The bench drives inputs on the falling edge and keeps a cycle-exact reference count, updated at each rising edge. It compares the output at the following falling edge, so every comparison lands half a period after the edge that should have changed it. Directed sequences apply reset in idle, in each wait state and in the acknowledge state. They also abort after one and two low edges. Seeded random select patterns then cover holds of many lengths.

// File: rtl/wack_pkg.sv
// Package: types shared by the wait-state generator.
// Assumes: nothing beyond being compiled first.
package wack_pkg;

    // Coarse phase of the machine as seen by the output stage.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACK  = 2'd2
    } phase_t;

endpackage

// File: rtl/wack_counter.sv
// Module: wack_counter
// Counts consecutive edges that sample the select low, saturating at
// WAIT_CYCLES, and reports the phase the machine enters at the next edge.
// Assumes: synchronous active-low reset; WAIT_CYCLES >= 1.
module wack_counter
    import wack_pkg::*;
#(
    parameter int WAIT_CYCLES = 3,
    parameter int CW          = $clog2(WAIT_CYCLES + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel_n,
    output phase_t phase_nxt
);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Next count: reset and released select clear, otherwise step to LAST.
    always_comb begin
        if (!rst_n)            cnt_d = '0;
        else if (sel_n)        cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + CW'(1);
        else                   cnt_d = cnt_q;
    end

    // Count register.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    // Phase decode of the next count for the output stage.
    always_comb begin
        if (cnt_d == LAST)     phase_nxt = PH_ACK;
        else if (cnt_d == '0)  phase_nxt = PH_IDLE;
        else                   phase_nxt = PH_WAIT;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0);                                  // R5
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> cnt_q == '0);                                   // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + CW'(1)); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && cnt_q == LAST) |=> cnt_q == LAST);             // R6

endmodule

// File: rtl/wack_ack_reg.sv
// Module: wack_ack_reg
// Registers the active-low acknowledge from the phase the counter enters.
// Assumes: synchronous active-low reset; phase_nxt already reflects sel_n.
module wack_ack_reg
    import wack_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel_n,
    input  phase_t phase_nxt,
    output logic   ack_n
);
    // Acknowledge register; reset wins over the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_n <= 1'b1;
        else        ack_n <= (phase_nxt != PH_ACK);
    end

    AST_RESET_ACK_HIGH: assert property (@(posedge clk)
        !rst_n |=> ack_n);                                        // R5
    AST_RELEASE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> ack_n);                                         // R3
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !sel_n) |=> !ack_n);                           // R6

endmodule

// File: rtl/wait_ack_gen.sv
// Module: wait_ack_gen (top)
// Inserts WAIT_CYCLES wait states after the select goes low, then holds the
// acknowledge low until the select is released.
// Assumes: sel_n synchronous to clk; rst_n synchronous active-low.
module wait_ack_gen
    import wack_pkg::*;
#(
    parameter int WAIT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    output logic xfer_ack_n
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    phase_t phase_nxt;

    wack_counter #(.WAIT_CYCLES(WAIT_CYCLES), .CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .phase_nxt (phase_nxt)
    );

    wack_ack_reg u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .phase_nxt (phase_nxt),
        .ack_n     (xfer_ack_n)
    );

endmodule

// File: tb/wait_ack_gen_tb.sv
`timescale 1ns/1ps
module wait_ack_gen_tb;
    localparam int W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic xfer_ack_n;
    int   total = 0;
    int   bad = 0;
    int   mcnt = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    wait_ack_gen #(.WAIT_CYCLES(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .xfer_ack_n(xfer_ack_n)
    );

    // Reference count from the requirements.
    function automatic int ref_next(int c, logic s, logic r);
        if (!r)      return 0;
        if (s)       return 0;
        if (c < W)   return c + 1;
        return W;
    endfunction

    function automatic logic ref_ack(int c);
        return (c == W) ? 1'b0 : 1'b1;
    endfunction

    task automatic check(input string tag);
        total++;
        if (xfer_ack_n !== ref_ack(mcnt)) begin
            bad++;
            $display("FAIL %s t=%0t ack_n actual=%b expected=%b",
                     tag, $time, xfer_ack_n, ref_ack(mcnt));
        end
    endtask

    // Drive at falling edge, model at rising edge, compare at next falling edge.
    task automatic step(input logic s, input logic r, input string tag);
        sel_n = s;
        rst_n = r;
        @(posedge clk);
        mcnt = ref_next(mcnt, s, r);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(1'b1, 1'b0, "R1 reset");
        step(1'b0, 1'b0, "R1 reset with select low");
        step(1'b1, 1'b1, "R1 idle after reset");

        // R2 exact assertion cycle, R6 hold, R3 release
        step(1'b0, 1'b1, "R2 edge1");
        step(1'b0, 1'b1, "R2 edge2");
        step(1'b0, 1'b1, "R2 edge3 ack low");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R6 hold");
        step(1'b1, 1'b1, "R3 release");

        // R4 abort after one and two low edges, R7 full restart
        step(1'b0, 1'b1, "R4 one");
        step(1'b1, 1'b1, "R4 abort1");
        step(1'b0, 1'b1, "R4 a");
        step(1'b0, 1'b1, "R4 b");
        step(1'b1, 1'b1, "R4 abort2");
        step(1'b0, 1'b1, "R7 restart1");
        step(1'b0, 1'b1, "R7 restart2");
        step(1'b0, 1'b1, "R7 restart3");
        step(1'b1, 1'b1, "R3 release2");
        step(1'b0, 1'b1, "R7 back-to-back1");
        step(1'b0, 1'b1, "R7 back-to-back2");
        step(1'b0, 1'b1, "R7 back-to-back3");

        // R5 reset in each state, then full delay again
        for (int k = 0; k <= W; k++) begin
            step(1'b1, 1'b1, "R5 prep");
            for (int j = 0; j < k; j++) step(1'b0, 1'b1, "R5 advance");
            step(1'b0, 1'b0, "R5 reset in state");
            for (int j = 0; j < W + 1; j++) step(1'b0, 1'b1, "R5 R7 after reset");
        end

        // Seeded random select patterns with occasional reset
        for (int n = 0; n < 3000; n++) begin
            logic s;
            logic r;
            s = ($urandom % 4) == 0;
            r = ($urandom % 25) != 0;
            if (!s) step(1'b0, r, "R2 R6 random");
            else    step(1'b1, r, "R3 R4 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule